// File: doc/BRIEF.md
# NAND Boot Copy Engine

This block is a hardware boot loader. After reset it samples a two-bit boot-mode strap on the first clock edge. The strap selects a boot source. The source is either the USB device port or a raw NAND flash on chip select 1, in a small-page or a large-page flavour.

In the NAND modes the engine first reads one configuration byte. It uses a conservative setup for this read: an 8-bit bus, page 0, column 0 and three row-address cycles. The byte then decides the data-bus width and the row-cycle count used for the rest of the boot. The engine then reads the flash page by page and writes the first `COPY_BYTES` (8 KB) into on-chip SRAM through a simple write port. When the last byte is written, it pulses a done flag and presents the entry address.

In USB mode the engine only raises a handoff flag. The reserved strap value raises an error flag and leaves the flash bus idle. ECC, bad-block handling and the USB transfer itself belong to other blocks.

Top module: `nand_boot_copy`

## Requirements
- R1: The strap `boot_mode_i` is sampled on the first clock after reset release: 2'b00 is reserved (error), 2'b01 is USB boot, 2'b10 is NAND with 512-byte pages, 2'b11 is NAND with 2048-byte pages.
- R2: With strap 2'b00, `boot_err_o` is high and the flash bus stays inactive: `nand_ce1_no`, `nand_we_no` and `nand_re_no` are high, `nand_cle_o` and `nand_ale_o` are low, and no SRAM write occurs.
- R3: With strap 2'b01, `usb_boot_o` is high, no flash strobe or chip select is asserted, no SRAM write occurs and no done pulse is given.
- R4: In NAND boot, `nand_ce1_no` is low whenever a WE# or RE# strobe is low, and it returns high after the done pulse.
- R5: The first read sequence uses page 0, column 0 and three row cycles, and reads a single byte on `nand_dq_i[7:0]`. This byte is not written to SRAM.
- R6: For the configuration byte: bits [7:4] all zero select a 16-bit bus, otherwise 8-bit. Bits [3:0] all zero select 2 row cycles, otherwise 3. The value 8'hFF therefore gives an 8-bit bus with 3 row cycles.
- R7: A small-page read issues command 8'h00 with CLE high, then one column byte 8'h00 with ALE high, then the row bytes with the least significant byte first (the first row byte is the page number and the others are zero), and then it waits. A copy reads 512 bytes per page.
- R8: A large-page read issues command 8'h00, then two column bytes 8'h00, then the row bytes, then command 8'h30. A copy reads 2048 bytes per page.
- R9: Every WE# and RE# strobe is low for exactly `STROBE_W` clocks (default 2). WE# and RE# are never low together.
- R10: After the last command or address cycle, the engine waits `TWB_CYC` clocks and then waits for R/B# high. RE# falls no earlier than the second clock after R/B# is seen high, and RE# is never low while R/B# is low.
- R11: On a 16-bit bus each read writes two bytes with `sram_be_o` = 2'b11 at an even address that advances by 2, and the low data byte goes to the lower address. On an 8-bit bus each read writes one byte with `sram_be_o` = 2'b01, and the address advances by 1.
- R12: Exactly `COPY_BYTES` bytes are written. Flash byte n (in page-major order) lands at SRAM byte address n, for n from 0 to `COPY_BYTES`-1.
- R13: `boot_done_o` is a single-cycle pulse given after the last SRAM write. `boot_addr_o` is zero before the pulse and equals `ENTRY_ADDR` from the pulse onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| boot_mode_i | input | 2 | Boot-mode strap |
| nand_ce1_no | output | 1 | Flash chip select 1, active low |
| nand_cle_o | output | 1 | Command latch enable |
| nand_ale_o | output | 1 | Address latch enable |
| nand_we_no | output | 1 | Write strobe, active low |
| nand_re_no | output | 1 | Read strobe, active low |
| nand_rb_i | input | 1 | Ready/busy, low while busy |
| nand_dq_i | input | 16 | Flash data in |
| nand_dq_o | output | 16 | Flash command/address out |
| nand_dq_oe_o | output | 1 | Output enable for nand_dq_o |
| sram_we_o | output | 1 | SRAM write enable |
| sram_addr_o | output | 13 | SRAM byte address |
| sram_wdata_o | output | 16 | SRAM write data |
| sram_be_o | output | 2 | SRAM byte enables |
| usb_boot_o | output | 1 | USB boot handoff flag |
| boot_err_o | output | 1 | Reserved-strap error flag |
| boot_done_o | output | 1 | Copy-complete pulse |
| boot_addr_o | output | 32 | Entry address, valid from done |

## Verification
The bench targets configuration bytes at the decode edges: 8'hFF, 8'h00, 8'h0F and 8'hF0, in both page flavours. A design that swaps the width and row-cycle nibbles, or inverts either test, sends the wrong number of row bytes or writes with the wrong byte enables. A flash model checks every command sequence against the expected page number and cycle count. A design that leaves out the 8'h30 confirm, or keeps the three-cycle setup after configuration, is caught at the sequence. The R/B# busy time is random. A design that reads without waiting for ready, or too soon after ready, is flagged. A full comparison of the SRAM image catches a lost or duplicated byte at a page boundary, as well as a done pulse that comes before the last write.

// File: rtl/nbc_pkg.sv
package nbc_pkg;
  typedef enum logic [3:0] {
    ST_STRAP, ST_ERR, ST_USB, ST_ISSUE, ST_TWB, ST_BUSY, ST_GAP, ST_READ, ST_FIN
  } nbc_state_e;

  localparam logic [1:0] MODE_NONE  = 2'b00;
  localparam logic [1:0] MODE_USB   = 2'b01;
  localparam logic [1:0] MODE_SMALL = 2'b10;
  localparam logic [1:0] MODE_LARGE = 2'b11;

  localparam logic [7:0] OP_READ    = 8'h00;
  localparam logic [7:0] OP_READ_GO = 8'h30;
endpackage

// File: rtl/nbc_strobe.sv
// One bus cycle: STROBE_W clocks low then STROBE_W clocks high.
module nbc_strobe #(
  parameter int STROBE_W = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic active_o,
  output logic low_o,
  output logic sample_o,
  output logic end_o
);
  localparam int SW = (2 * STROBE_W > 1) ? $clog2(2 * STROBE_W) : 1;
  localparam logic [SW-1:0] LAST_C = SW'(2 * STROBE_W - 1);
  localparam logic [SW-1:0] LOW_C  = SW'(STROBE_W);

  logic [SW-1:0] cnt_q;
  logic          act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (start_i) begin
      cnt_q <= '0;
      act_q <= 1'b1;
    end else if (act_q) begin
      if (cnt_q == LAST_C) act_q <= 1'b0;
      else                 cnt_q <= cnt_q + 1'b1;
    end
  end

  assign active_o = act_q;
  assign low_o    = act_q && (cnt_q < LOW_C);
  assign sample_o = act_q && (cnt_q == LOW_C - 1'b1);
  assign end_o    = act_q && (cnt_q == LAST_C);
endmodule

// File: rtl/nbc_step_decode.sv
// Maps a step index of a read-setup sequence to CLE/ALE and the bus byte.
module nbc_step_decode (
  input  logic [2:0] step_i,
  input  logic       large_i,
  input  logic       rows3_i,
  input  logic [7:0] page_i,
  output logic       cle_o,
  output logic       ale_o,
  output logic [7:0] byte_o,
  output logic       last_o
);
  import nbc_pkg::*;

  logic [2:0] ncol, nrow, last_idx;

  always_comb begin
    ncol     = large_i ? 3'd2 : 3'd1;
    nrow     = rows3_i ? 3'd3 : 3'd2;
    last_idx = ncol + nrow + {2'b00, large_i};
    last_o   = (step_i == last_idx);
    cle_o    = (step_i == 3'd0) || (large_i && last_o);
    ale_o    = !cle_o;
    if (step_i == 3'd0)             byte_o = OP_READ;
    else if (cle_o)                 byte_o = OP_READ_GO;
    else if (step_i == ncol + 3'd1) byte_o = page_i;  // row LSB first
    else                            byte_o = 8'h00;
  end
endmodule

// File: rtl/nand_boot_copy.sv
module nand_boot_copy #(
  parameter int          COPY_BYTES = 8192,
  parameter int          SMALL_PAGE = 512,
  parameter int          LARGE_PAGE = 2048,
  parameter int          STROBE_W   = 2,
  parameter int          TWB_CYC    = 2,
  parameter logic [31:0] ENTRY_ADDR = 32'h8000_0000,
  localparam int         AW         = $clog2(COPY_BYTES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    boot_mode_i,
  output logic          nand_ce1_no,
  output logic          nand_cle_o,
  output logic          nand_ale_o,
  output logic          nand_we_no,
  output logic          nand_re_no,
  input  logic          nand_rb_i,
  input  logic [15:0]   nand_dq_i,
  output logic [15:0]   nand_dq_o,
  output logic          nand_dq_oe_o,
  output logic          sram_we_o,
  output logic [AW-1:0] sram_addr_o,
  output logic [15:0]   sram_wdata_o,
  output logic [1:0]    sram_be_o,
  output logic          usb_boot_o,
  output logic          boot_err_o,
  output logic          boot_done_o,
  output logic [31:0]   boot_addr_o
);
  import nbc_pkg::*;

  localparam int CW = AW + 1;
  localparam int TW = (TWB_CYC > 1) ? $clog2(TWB_CYC) : 1;
  localparam logic [CW-1:0] FULL_C  = CW'(COPY_BYTES);
  localparam logic [CW-1:0] SMASK_C = CW'(SMALL_PAGE - 1);
  localparam logic [CW-1:0] LMASK_C = CW'(LARGE_PAGE - 1);

  nbc_state_e    state_q;
  logic          cfg_q, wide_q, rows3_q, large_q;
  logic [2:0]    step_q;
  logic [7:0]    page_q;
  logic [CW-1:0] byte_cnt_q, cnt_next;
  logic [TW-1:0] wait_q;
  logic          copy_full, page_edge;

  logic stb_start, stb_active, stb_low, stb_sample, stb_end;
  logic dec_cle, dec_ale, dec_last;
  logic [7:0] dec_byte;

  nbc_strobe #(.STROBE_W(STROBE_W)) u_strobe (
    .clk_i, .rst_ni,
    .start_i (stb_start),
    .active_o(stb_active),
    .low_o   (stb_low),
    .sample_o(stb_sample),
    .end_o   (stb_end)
  );

  // configuration read always uses three row cycles
  nbc_step_decode u_step (
    .step_i (step_q),
    .large_i(large_q),
    .rows3_i(cfg_q | rows3_q),
    .page_i (page_q),
    .cle_o  (dec_cle),
    .ale_o  (dec_ale),
    .byte_o (dec_byte),
    .last_o (dec_last)
  );

  assign cnt_next  = byte_cnt_q + (wide_q ? CW'(2) : CW'(1));
  assign copy_full = (byte_cnt_q == FULL_C);
  assign page_edge = ((byte_cnt_q & (large_q ? LMASK_C : SMASK_C)) == '0);

  // back-to-back reads inside a page
  assign stb_start = ((state_q == ST_ISSUE) && !stb_active) ||
                     ((state_q == ST_READ) &&
                      (!stb_active || (stb_end && !cfg_q && !page_edge && !copy_full)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_STRAP;
      cfg_q      <= 1'b1;
      wide_q     <= 1'b0;
      rows3_q    <= 1'b1;
      large_q    <= 1'b0;
      step_q     <= '0;
      page_q     <= '0;
      byte_cnt_q <= '0;
      wait_q     <= '0;
    end else begin
      unique case (state_q)
        ST_STRAP: begin
          unique case (boot_mode_i)
            MODE_NONE:  state_q <= ST_ERR;
            MODE_USB:   state_q <= ST_USB;
            MODE_SMALL: begin large_q <= 1'b0; state_q <= ST_ISSUE; end
            default:    begin large_q <= 1'b1; state_q <= ST_ISSUE; end
          endcase
        end
        ST_ISSUE: if (stb_end) begin
          if (dec_last) begin
            step_q  <= '0;
            wait_q  <= '0;
            state_q <= ST_TWB;
          end else begin
            step_q <= step_q + 3'd1;
          end
        end
        ST_TWB: begin
          if (wait_q == TW'(TWB_CYC - 1)) state_q <= ST_BUSY;
          else                             wait_q  <= wait_q + 1'b1;
        end
        ST_BUSY: if (nand_rb_i) state_q <= ST_GAP;
        ST_GAP:  state_q <= ST_READ;
        ST_READ: begin
          if (stb_sample) begin
            if (cfg_q) begin
              wide_q  <= (nand_dq_i[7:4] == 4'h0);
              rows3_q <= (nand_dq_i[3:0] != 4'h0);
            end else begin
              byte_cnt_q <= cnt_next;
            end
          end
          if (stb_end) begin
            if (cfg_q) begin
              cfg_q   <= 1'b0;
              state_q <= ST_ISSUE;
            end else if (copy_full) begin
              state_q <= ST_FIN;
            end else if (page_edge) begin
              page_q  <= page_q + 8'd1;
              state_q <= ST_ISSUE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sram_we_o    <= 1'b0;
      sram_addr_o  <= '0;
      sram_wdata_o <= '0;
      sram_be_o    <= '0;
      boot_done_o  <= 1'b0;
      boot_addr_o  <= '0;
    end else begin
      sram_we_o   <= (state_q == ST_READ) && stb_sample && !cfg_q;
      boot_done_o <= (state_q == ST_READ) && stb_end && !cfg_q && copy_full;
      if (stb_sample) begin
        sram_addr_o  <= byte_cnt_q[AW-1:0];
        sram_wdata_o <= wide_q ? nand_dq_i : {8'h00, nand_dq_i[7:0]};
        sram_be_o    <= wide_q ? 2'b11 : 2'b01;
      end
      if ((state_q == ST_READ) && stb_end && !cfg_q && copy_full)
        boot_addr_o <= ENTRY_ADDR;
    end
  end

  logic nand_busy;
  assign nand_busy    = (state_q == ST_ISSUE) || (state_q == ST_TWB) || (state_q == ST_BUSY) ||
                        (state_q == ST_GAP)   || (state_q == ST_READ);
  assign nand_ce1_no  = !nand_busy;
  assign nand_cle_o   = (state_q == ST_ISSUE) && dec_cle;
  assign nand_ale_o   = (state_q == ST_ISSUE) && dec_ale;
  assign nand_dq_o    = {8'h00, dec_byte};
  assign nand_dq_oe_o = (state_q == ST_ISSUE);
  assign nand_we_no   = !((state_q == ST_ISSUE) && stb_low);
  assign nand_re_no   = !((state_q == ST_READ) && stb_low);
  assign usb_boot_o   = (state_q == ST_USB);
  assign boot_err_o   = (state_q == ST_ERR);
endmodule

// File: rtl/nbc_checker.sv
module nbc_checker #(
  parameter int STROBE_W = 2
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       nand_ce1_no,
  input logic       nand_cle_o,
  input logic       nand_ale_o,
  input logic       nand_we_no,
  input logic       nand_re_no,
  input logic       nand_rb_i,
  input logic       sram_we_o,
  input logic [1:0] sram_be_o,
  input logic       usb_boot_o,
  input logic       boot_err_o,
  input logic       boot_done_o
);
  AST_ERR_BUS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boot_err_o |-> (nand_ce1_no && nand_we_no && nand_re_no && !nand_cle_o && !nand_ale_o && !sram_we_o)); // R2

  AST_USB_NO_FLASH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    usb_boot_o |-> (nand_ce1_no && nand_we_no && nand_re_no && !sram_we_o && !boot_done_o)); // R3

  AST_CE_WITH_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!nand_we_no || !nand_re_no) |-> !nand_ce1_no); // R4

  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!nand_we_no && !nand_re_no)); // R9

  AST_NO_READ_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !nand_re_no |-> nand_rb_i); // R10

  AST_BE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_we_o |-> (sram_be_o == 2'b01 || sram_be_o == 2'b11)); // R11

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boot_done_o |=> !boot_done_o); // R13

  generate
    if (STROBE_W >= 2) begin : g_min_low
      AST_WE_MIN_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(nand_we_no) |=> !nand_we_no); // R9
      AST_RE_MIN_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(nand_re_no) |=> !nand_re_no); // R9
    end
  endgenerate
endmodule

bind nand_boot_copy nbc_checker #(.STROBE_W(STROBE_W)) u_nbc_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .nand_ce1_no (nand_ce1_no),
  .nand_cle_o  (nand_cle_o),
  .nand_ale_o  (nand_ale_o),
  .nand_we_no  (nand_we_no),
  .nand_re_no  (nand_re_no),
  .nand_rb_i   (nand_rb_i),
  .sram_we_o   (sram_we_o),
  .sram_be_o   (sram_be_o),
  .usb_boot_o  (usb_boot_o),
  .boot_err_o  (boot_err_o),
  .boot_done_o (boot_done_o)
);

// File: tb/tb_nand_boot_copy.sv
module tb_nand_boot_copy;
  localparam int CLK_NS = 10;
  localparam int W      = 2;
  localparam int COPY   = 8192;
  localparam logic [31:0] ENTRY = 32'h8000_0000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  boot_mode_i = 2'b00;
  logic        nand_ce1_no, nand_cle_o, nand_ale_o, nand_we_no, nand_re_no;
  logic        nand_rb_i = 1'b1;
  logic [15:0] nand_dq_i, nand_dq_o;
  logic        nand_dq_oe_o, sram_we_o;
  logic [12:0] sram_addr_o;
  logic [15:0] sram_wdata_o;
  logic [1:0]  sram_be_o;
  logic        usb_boot_o, boot_err_o, boot_done_o;
  logic [31:0] boot_addr_o;

  nand_boot_copy #(.STROBE_W(W), .ENTRY_ADDR(ENTRY)) dut (.*);

  always #(CLK_NS/2) clk_i = ~clk_i;

  int checks = 0, fails = 0;
  bit finished = 0;

  // test context
  logic [7:0] cfg_t;
  int  salt_t, pb_t, rows_t;
  bit  large_t, wide_t;

  // flash model state
  int  seq_idx, seq_page, na, col, busy_left, gap_cnt;
  bit  gap_trk, prev_we, prev_re;
  logic [7:0] ab [8];
  int  we_run, re_run;
  int  seq_bad, strobe_bad, gap_bad, be_bad, addr_bad, wr_bytes, exp_addr, done_cnt, done_bytes;
  logic [7:0] bmem [COPY];

  function automatic logic [7:0] fb(input int a);
    int v;
    if (a == 0) return cfg_t;
    v = a * 29 + (a >> 9) * 7 + salt_t;
    return v[7:0];
  endfunction

  assign nand_dq_i = wide_t ? {fb(seq_page * pb_t + 2 * col + 1), fb(seq_page * pb_t + 2 * col)}
                            : {8'h00, fb(seq_page * pb_t + col)};

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic end_seq();
    int ncol, nr, pg;
    bit ok;
    ncol = large_t ? 2 : 1;
    nr   = (seq_idx == 0) ? 3 : rows_t;
    pg   = (seq_idx == 0) ? 0 : seq_idx - 1;
    ok   = (na == ncol + nr);
    for (int i = 0; i < 8; i++)
      if (i < na) begin
        if (i == ncol) begin if (ab[i] != pg[7:0]) ok = 0; end
        else if (ab[i] != 8'h00) ok = 0;
      end
    if (!ok) seq_bad++;
    seq_page  = pg;
    col       = 0;
    seq_idx++;
    busy_left = $urandom_range(3, 12);
    nand_rb_i = 1'b0;
  endtask

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      prev_we = 1; prev_re = 1; we_run = 0; re_run = 0;
    end else begin
      if (gap_trk) begin
        if (!nand_re_no) begin if (gap_cnt < 2) gap_bad++; gap_trk = 0; end
        else gap_cnt++;
      end
      if (busy_left > 0) begin
        busy_left--;
        if (busy_left == 0) begin nand_rb_i = 1'b1; gap_trk = 1; gap_cnt = 0; end
      end
      if (!nand_we_no) we_run++;
      if (!nand_re_no) re_run++;
      if (!prev_we && nand_we_no) begin
        if (we_run != W) strobe_bad++;
        we_run = 0;
        if (nand_cle_o && nand_dq_o[7:0] == 8'h00) begin na = 0; col = 0; end
        else if (nand_cle_o && nand_dq_o[7:0] == 8'h30) begin
          if (!large_t) seq_bad++;
          end_seq();
        end else if (nand_ale_o) begin
          if (na < 8) ab[na] = nand_dq_o[7:0];
          na++;
          if (!large_t && na == 1 + ((seq_idx == 0) ? 3 : rows_t)) end_seq();
        end else seq_bad++;
      end
      if (!prev_re && nand_re_no) begin
        if (re_run != W) strobe_bad++;
        re_run = 0;
        col++;
      end
      if (sram_we_o) begin
        if (sram_be_o != (wide_t ? 2'b11 : 2'b01)) be_bad++;
        if (int'(sram_addr_o) != exp_addr) addr_bad++;
        bmem[sram_addr_o] = sram_wdata_o[7:0];
        wr_bytes++;
        exp_addr++;
        if (sram_be_o[1]) begin
          bmem[sram_addr_o + 13'd1] = sram_wdata_o[15:8];
          wr_bytes++;
          exp_addr++;
        end
      end
      if (boot_done_o) begin done_cnt++; done_bytes = wr_bytes; end
      prev_we = nand_we_no;
      prev_re = nand_re_no;
    end
  end

  task automatic start_test(input logic [1:0] mode, input logic [7:0] cfg, input int salt);
    @(negedge clk_i);
    rst_ni = 1'b0;
    boot_mode_i = mode;
    cfg_t   = cfg;
    salt_t  = salt;
    large_t = (mode == 2'b11);
    pb_t    = large_t ? 2048 : 512;
    wide_t  = (cfg[7:4] == 4'h0);
    rows_t  = (cfg[3:0] != 4'h0) ? 3 : 2;
    seq_idx = 0; seq_page = 0; na = 0; col = 0; busy_left = 0; gap_trk = 0;
    seq_bad = 0; strobe_bad = 0; gap_bad = 0; be_bad = 0; addr_bad = 0;
    wr_bytes = 0; exp_addr = 0; done_cnt = 0; done_bytes = -1;
    nand_rb_i = 1'b1;
    for (int i = 0; i < COPY; i++) bmem[i] = 'x;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic run_nand(input logic [1:0] mode, input logic [7:0] cfg, input int salt);
    int n, mism, ce_bad;
    string tag;
    tag = $sformatf("cfg=%02h mode=%0d", cfg, mode);
    start_test(mode, cfg, salt);
    n = 0;
    while (done_cnt == 0 && n < 60000) begin @(negedge clk_i); n++; end
    repeat (20) @(negedge clk_i);
    ce_bad = nand_ce1_no ? 0 : 1;
    mism = 0;
    for (int i = 0; i < COPY; i++) if (bmem[i] !== fb(i)) mism++;
    chk(seq_bad == 0, "R5 R7 R8", {"bad command sequences ", tag}, seq_bad, 0);
    chk(seq_idx == 1 + COPY / pb_t, "R7 R8", {"read sequences ", tag}, seq_idx, 1 + COPY / pb_t);
    chk(be_bad == 0, "R6 R11", {"byte-enable width ", tag}, be_bad, 0);
    chk(addr_bad == 0, "R11", {"address stepping ", tag}, addr_bad, 0);
    chk(mism == 0 && wr_bytes == COPY, "R12", {"image mismatches ", tag}, mism, 0);
    chk(done_cnt == 1 && done_bytes == COPY, "R13", {"done after last write ", tag}, done_bytes, COPY);
    chk(boot_addr_o == ENTRY, "R13", {"entry address ", tag}, int'(boot_addr_o), int'(ENTRY));
    chk(strobe_bad == 0, "R9", {"strobe widths ", tag}, strobe_bad, 0);
    chk(gap_bad == 0, "R10", {"ready-to-read gap ", tag}, gap_bad, 0);
    chk(ce_bad == 0, "R4", {"chip select released ", tag}, ce_bad, 0);
  endtask

  task automatic run_quiet(input logic [1:0] mode);
    int act;
    start_test(mode, 8'hFF, 0);
    act = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk_i);
      if (!nand_ce1_no || !nand_we_no || !nand_re_no || nand_cle_o || nand_ale_o || sram_we_o || boot_done_o)
        act++;
    end
    if (mode == 2'b00) begin
      chk(boot_err_o && !usb_boot_o, "R1 R2", "error flag for strap 00", boot_err_o, 1);
      chk(act == 0, "R2", "bus activity with strap 00", act, 0);
    end else begin
      chk(usb_boot_o && !boot_err_o, "R1 R3", "usb flag for strap 01", usb_boot_o, 1);
      chk(act == 0, "R3", "flash activity in usb boot", act, 0);
    end
  endtask

  initial begin
    #(CLK_NS * 199000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    cfg_t = 8'hFF; salt_t = 0; pb_t = 512; wide_t = 0; rows_t = 3; large_t = 0;
    repeat (3) @(negedge clk_i);
    chk(nand_ce1_no && nand_we_no && nand_re_no && !boot_done_o && !boot_err_o && !usb_boot_o,
        "R2 R13", "outputs idle in reset", 0, 0);
    chk(boot_addr_o == 32'h0, "R13", "entry address zero in reset", int'(boot_addr_o), 0);
    run_quiet(2'b00);
    run_quiet(2'b01);
    run_nand(2'b10, 8'hFF, 3);   // R6 8-bit, 3 rows
    run_nand(2'b11, 8'h00, 5);   // R6 16-bit, 2 rows
    run_nand(2'b10, 8'h0F, 7);   // 16-bit, 3 rows
    run_nand(2'b11, 8'hF0, 11);  // 8-bit, 2 rows
    for (int k = 0; k < 2; k++)
      run_nand(2'($urandom_range(2, 3)), 8'($urandom_range(0, 255)), int'($urandom_range(0, 255)));
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule